// File: doc/BRIEF.md
# Halfword Odd-Parity Generator and Checker

This block guards a 16-bit memory word with two odd-parity bits, one per 8-bit halfword. On the write side it works out the parity bit for each halfword of the outgoing data. On the read side it reduces each halfword's eight data bits together with its stored parity bit, and flags any halfword whose nine bits hold an even count of ones.

The block follows a stepped machine cycle. The host supplies a 3-bit step number and a qualifier that marks the step as real. Write parity is captured only at the generation step (step 4) and then holds. The read check is sampled only at the check step (step 6). A failed check sets a sticky error latch that drives a machine-stop output and records the failing halfwords. The latch stays set until the host pulses a clear input.

Halfword 1 is `wr_data[15:8]` / `rd_data[15:8]` with parity bit index 1. Halfword 0 is bits `[7:0]` with parity bit index 0.

Top module: `hwpar_guard`

## Requirements
- R1: When generation fires, `wr_par[k]` becomes 1 exactly when halfword k of `wr_data` holds an even number of 1 bits. The nine bits then always hold an odd count.
- R2: Generation fires only on a clock edge where `step_vld` is 1 and `step` equals 4. On every other edge, `wr_par` keeps its value.
- R3: The word 0x1001 yields `wr_par` = 2'b00. Read back with parity 2'b00 and checked at step 6, it leaves `stop` low.
- R4: `even_n[k]` is combinational and is 0 exactly when the eight read bits of halfword k plus `rd_par[k]` hold an even count of ones. Otherwise it is 1.
- R5: On an edge where `step_vld` is 1, `step` equals 6, `chk_clr` is 0 and either `even_n` bit is 0, `stop` is 1 after that edge.
- R6: A read word with bad parity has no effect on `stop` or `err_half` on any edge other than a qualified step-6 edge.
- R7: Once set, `stop` and `err_half` stay set through later checks, including clean ones, until a clear.
- R8: `err_half[k]` records that halfword k failed a qualified check. Further failures while the latch is set OR into the record.
- R9: `chk_clr` high at an edge clears `stop` and `err_half` after that edge. It wins over a failing check on the same edge.
- R10: After synchronous reset, `wr_par`, `stop` and `err_half` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 3 | Current machine step number |
| step_vld | input | 1 | Step number is a real step of the cycle |
| wr_data | input | 16 | Word being written |
| wr_par | output | 2 | Registered odd-parity bits for the written word |
| rd_data | input | 16 | Word read from memory |
| rd_par | input | 2 | Parity bits read from memory |
| chk_clr | input | 1 | Clears the error latch |
| even_n | output | 2 | Per-halfword active-low even-parity indication |
| stop | output | 1 | Machine stop, set by a failed check |
| err_half | output | 2 | Sticky record of failing halfwords |

## Verification
The bench builds the block with its default parameters: two 8-bit halfwords, a 3-bit step, generation at step 4 and checking at step 6. These values let the bench walk all eight step numbers with and without the qualifier. With them it can show that only the two chosen steps act. The narrow halfword also lets it cover the all-zero, all-one, single-bit and mixed patterns, as well as failures in either halfword or both.

// File: rtl/hwpar_pkg.sv
package hwpar_pkg;

    localparam int HALF_W   = 8;
    localparam int HALVES   = 2;
    localparam int WORD_W   = HALF_W * HALVES;
    localparam int STEP_W   = 3;
    localparam int GEN_STEP = 4;
    localparam int CHK_STEP = 6;

    // Sticky error record carried between the check logic and the outputs.
    typedef struct packed {
        logic              halt;
        logic [HALVES-1:0] which;
    } err_rec_t;

    // Decoded step strobes for one edge.
    typedef struct packed {
        logic gen_fire;
        logic chk_fire;
    } step_strobe_t;

    function automatic logic [STEP_W-1:0] step_code(input int n);
        return STEP_W'(n);
    endfunction

endpackage

// File: rtl/hwpar_tree.sv
// XOR reduction of W bits; odd_q is high when the count of ones is odd.
module hwpar_tree #(
    parameter int W = 9
) (
    input  logic [W-1:0] bits,
    output logic         odd_q
);
    logic [W:0] acc;

    assign acc[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_chain
        assign acc[i+1] = acc[i] ^ bits[i];
    end

    assign odd_q = acc[W];
endmodule

// File: rtl/hwpar_gen.sv
// Write-side parity: one tree per halfword, registered at the generation step.
module hwpar_gen
    import hwpar_pkg::*;
#(
    parameter int HW = HALF_W,
    parameter int NH = HALVES
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           fire,
    input  logic [HW*NH-1:0] data,
    output logic [NH-1:0]  par_q
);
    logic [NH-1:0] odd_v;

    for (genvar k = 0; k < NH; k++) begin : g_half
        hwpar_tree #(.W(HW)) u_tree (
            .bits  (data[k*HW +: HW]),
            .odd_q (odd_v[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            par_q <= '0;
        end else if (fire) begin
            par_q <= ~odd_v;
        end
    end
endmodule

// File: rtl/hwpar_latch.sv
// Read-side check: nine-bit trees per halfword and the sticky stop latch.
module hwpar_latch
    import hwpar_pkg::*;
#(
    parameter int HW = HALF_W,
    parameter int NH = HALVES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic             clr,
    input  logic [HW*NH-1:0] data,
    input  logic [NH-1:0]    par,
    output logic [NH-1:0]    even_n,
    output err_rec_t         rec_q
);
    for (genvar k = 0; k < NH; k++) begin : g_half
        hwpar_tree #(.W(HW + 1)) u_tree (
            .bits  ({par[k], data[k*HW +: HW]}),
            .odd_q (even_n[k])
        );
    end

    logic [NH-1:0] bad;
    err_rec_t      rec_d;

    assign bad = ~even_n;

    always_comb begin
        rec_d = rec_q;
        if (clr) begin
            rec_d = '0;
        end else if (fire && (bad != '0)) begin
            rec_d.halt  = 1'b1;
            rec_d.which = rec_q.which | bad;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q <= '0;
        end else begin
            rec_q <= rec_d;
        end
    end
endmodule

// File: rtl/hwpar_guard.sv
module hwpar_guard
    import hwpar_pkg::*;
#(
    parameter int HW      = HALF_W,
    parameter int NH      = HALVES,
    parameter int SW      = STEP_W,
    parameter int GEN_AT  = GEN_STEP,
    parameter int CHK_AT  = CHK_STEP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SW-1:0]    step,
    input  logic             step_vld,
    input  logic [HW*NH-1:0] wr_data,
    output logic [NH-1:0]    wr_par,
    input  logic [HW*NH-1:0] rd_data,
    input  logic [NH-1:0]    rd_par,
    input  logic             chk_clr,
    output logic [NH-1:0]    even_n,
    output logic             stop,
    output logic [NH-1:0]    err_half
);
    localparam logic [SW-1:0] GEN_CODE = SW'(GEN_AT);
    localparam logic [SW-1:0] CHK_CODE = SW'(CHK_AT);

    step_strobe_t strobe;
    err_rec_t     rec;

    assign strobe.gen_fire = step_vld && (step == GEN_CODE);
    assign strobe.chk_fire = step_vld && (step == CHK_CODE);

    hwpar_gen #(.HW(HW), .NH(NH)) u_gen (
        .clk   (clk),
        .rst   (rst),
        .fire  (strobe.gen_fire),
        .data  (wr_data),
        .par_q (wr_par)
    );

    hwpar_latch #(.HW(HW), .NH(NH)) u_chk (
        .clk    (clk),
        .rst    (rst),
        .fire   (strobe.chk_fire),
        .clr    (chk_clr),
        .data   (rd_data),
        .par    (rd_par),
        .even_n (even_n),
        .rec_q  (rec)
    );

    assign stop     = rec.halt;
    assign err_half = rec.which;
endmodule

// File: rtl/hwpar_guard_chk.sv
module hwpar_guard_chk #(
    parameter int HW = 8,
    parameter int NH = 2,
    parameter int SW = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [SW-1:0]    step,
    input logic             step_vld,
    input logic [HW*NH-1:0] wr_data,
    input logic [NH-1:0]    wr_par,
    input logic             chk_clr,
    input logic [NH-1:0]    even_n,
    input logic             stop,
    input logic [NH-1:0]    err_half
);
    logic gen_e;
    logic chk_e;
    assign gen_e = step_vld && (step == SW'(4));
    assign chk_e = step_vld && (step == SW'(6));

    // R2
    wpar_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !gen_e |=> $stable(wr_par));

    // R1
    wpar_odd_chk: assert property (@(posedge clk) disable iff (rst)
        gen_e |=> ($countones({wr_par[0], $past(wr_data[HW-1:0])}) % 2 == 1));

    // R5
    stop_set_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_e && !chk_clr && (even_n != '1)) |=> stop);

    // R6
    stop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!stop && !chk_e) |=> !stop);

    // R7
    stop_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (stop && !chk_clr) |=> stop);

    // R9
    clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        chk_clr |=> (!stop && err_half == '0));

    // R8
    rec_grow_chk: assert property (@(posedge clk) disable iff (rst)
        (stop && !chk_clr) |=> ((err_half & $past(err_half)) == $past(err_half)));
endmodule

bind hwpar_guard hwpar_guard_chk #(.HW(HW), .NH(NH), .SW(SW)) u_guard_chk (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .step_vld (step_vld),
    .wr_data  (wr_data),
    .wr_par   (wr_par),
    .chk_clr  (chk_clr),
    .even_n   (even_n),
    .stop     (stop),
    .err_half (err_half)
);

// File: tb/hwpar_guard_test.sv
`timescale 1ns/1ps
module hwpar_guard_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  step = '0;
    logic        step_vld = 1'b0;
    logic [15:0] wr_data = '0;
    logic [1:0]  wr_par;
    logic [15:0] rd_data = '0;
    logic [1:0]  rd_par = '0;
    logic        chk_clr = 1'b0;
    logic [1:0]  even_n;
    logic        stop;
    logic [1:0]  err_half;

    always #2.5 clk = ~clk;

    hwpar_guard uut (
        .clk(clk), .rst(rst), .step(step), .step_vld(step_vld),
        .wr_data(wr_data), .wr_par(wr_par), .rd_data(rd_data),
        .rd_par(rd_par), .chk_clr(chk_clr), .even_n(even_n),
        .stop(stop), .err_half(err_half)
    );

    typedef struct {
        string    req;
        int       sel;   // 0 wr_par, 1 even_n, 2 stop, 3 err_half
        logic [1:0] exp;
    } item_t;

    item_t q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [1:0] m_wpar = '0;
    logic       m_stop = 1'b0;
    logic [1:0] m_err  = '0;

    function automatic logic even_cnt(input logic [8:0] b);
        int n = 0;
        for (int i = 0; i < 9; i++) if (b[i]) n++;
        return (n % 2) == 0;
    endfunction

    task automatic push(input string req, input int sel, input logic [1:0] e);
        item_t it;
        it.req = req; it.sel = sel; it.exp = e;
        q.push_back(it);
    endtask

    // Driver: apply one step, compute expected outputs after its edge.
    task automatic cyc(input string req, input logic [2:0] s, input logic v,
                       input logic [15:0] wd, input logic [15:0] rd,
                       input logic [1:0] rp, input logic clr);
        logic [1:0] ev;
        @(negedge clk); #1;
        step = s; step_vld = v; wr_data = wd; rd_data = rd;
        rd_par = rp; chk_clr = clr;
        @(posedge clk);
        if (v && s == 3'd4) begin
            m_wpar[1] = even_cnt({1'b0, wd[15:8]});
            m_wpar[0] = even_cnt({1'b0, wd[7:0]});
        end
        ev[1] = even_cnt({rp[1], rd[15:8]});
        ev[0] = even_cnt({rp[0], rd[7:0]});
        if (clr) begin
            m_stop = 1'b0; m_err = '0;
        end else if (v && s == 3'd6 && ev != 2'b00) begin
            m_stop = 1'b1; m_err = m_err | ev;
        end
        push(req, 0, m_wpar);
        push(req, 1, ~ev);
        push(req, 2, {1'b0, m_stop});
        push(req, 3, m_err);
    endtask

    // Monitor: compare queued expectations at the falling edge.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [1:0] act;
            it = q.pop_front();
            case (it.sel)
                0: act = wr_par;
                1: act = even_n;
                2: act = {1'b0, stop};
                default: act = err_half;
            endcase
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s sel=%0d actual=%b expected=%b", it.req, it.sel, act, it.exp);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        rst = 1'b0;
        // R10 reset state
        push("R10", 0, 2'b00);
        push("R10", 2, 2'b00);
        push("R10", 3, 2'b00);
        @(posedge clk);

        // R3 single bit per halfword
        cyc("R3", 3'd4, 1, 16'h1001, 16'h1001, 2'b00, 0);
        cyc("R3", 3'd6, 1, 16'h0000, 16'h1001, 2'b00, 0);
        // R1 patterns
        cyc("R1", 3'd4, 1, 16'h0000, 16'h0000, 2'b11, 0);
        cyc("R1", 3'd4, 1, 16'hFF01, 16'hFF01, 2'b10, 0);
        cyc("R1", 3'd4, 1, 16'h03FE, 16'h03FE, 2'b10, 0);
        for (int i = 1; i < 40; i++) begin
            logic [15:0] w;
            w = 16'(i * 16'h2B5D) ^ 16'(i << 3);
            cyc("R1", 3'd4, 1, w, w, 2'b00, 0);
            // R4 read with computed parity must be clean
            cyc("R4", 3'd5, 1, w, w, m_wpar, 0);
        end
        // R2 other steps and unqualified step 4 leave wr_par alone
        cyc("R1", 3'd4, 1, 16'h1001, 16'h0000, 2'b11, 0);
        for (int s = 0; s < 8; s++) begin
            cyc("R2", 3'(s), (s == 4) ? 1'b0 : 1'b1, 16'h0000, 16'h1001, 2'b00, 0);
        end
        // R6 bad low half on every non-check step, and on step 6 unqualified
        for (int s = 0; s < 8; s++) begin
            if (s != 6) cyc("R6", 3'(s), 1, 16'h0, 16'h1000, 2'b00, 0);
        end
        cyc("R6", 3'd6, 0, 16'h0, 16'h0010, 2'b01, 0);
        // R4 bad parity indications
        cyc("R4", 3'd2, 1, 16'h0, 16'h1001, 2'b11, 0);
        // R5 low half fails at step 6
        cyc("R5", 3'd6, 1, 16'h0, 16'h1000, 2'b00, 0);
        // R7 clean checks keep it set
        cyc("R7", 3'd6, 1, 16'h0, 16'h1001, 2'b00, 0);
        cyc("R7", 3'd3, 1, 16'h0, 16'h1001, 2'b00, 0);
        // R8 upper half adds to record
        cyc("R8", 3'd6, 1, 16'h0, 16'h0001, 2'b00, 0);
        // R9 clear
        cyc("R9", 3'd0, 1, 16'h0, 16'h1001, 2'b00, 1);
        // R9 clear wins over a failing check
        cyc("R9", 3'd6, 1, 16'h0, 16'h0000, 2'b00, 1);
        // R8 both halves at once
        cyc("R8", 3'd6, 1, 16'h0, 16'h0000, 2'b00, 0);
        cyc("R9", 3'd6, 1, 16'h0, 16'h1001, 2'b00, 1);
        cyc("R5", 3'd6, 1, 16'h0, 16'h0100, 2'b00, 0);
        cyc("R9", 3'd1, 0, 16'h0, 16'h1001, 2'b00, 1);

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule